// File: doc/BRIEF.md
# Shift-Fed Data-Processing ALU

This block is the combinational datapath behind register-to-register data-processing operations. The second operand passes through a barrel shifter before it reaches the arithmetic stage. The instruction supplies the shift kind and the shift amount. The shifter output then feeds a move path or an adder/subtractor. Shifting and arithmetic complete in one combinational pass, so an add of a left-shifted operand needs no extra cycle.

The block returns the operation result and a four-bit flag word. When the set-flags control is high, the flags are recomputed from the operation. When it is low, the incoming flag word passes through unchanged. The C bit of the incoming flag word also acts as the carry that a zero-amount shift leaves in place.

Top module: `shift_alu`

## Requirements
- R1: The shifter applies the selected kind to `op_b` by `shift_amt` (0..31) in the same combinational pass as the operation. The kind encodings are 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. As an example, ADD with logical left by 2 returns `op_a + 4*op_b`.
- R2: A shift amount of zero leaves `op_b` unchanged, whatever the kind. In that case the shifter carry equals the incoming C bit `flags_in[1]`.
- R3: Opcodes 00 (move) and 11 (alternate move) return the shifted `op_b`, and `op_a` has no effect on the result.
- R4: Opcode 01 (add) returns `op_a` plus the shifted `op_b`, modulo 2^32.
- R5: Opcode 10 (subtract) returns `op_a` minus the shifted `op_b`, in that order, modulo 2^32.
- R6: The flag word is ordered N=bit 3, Z=bit 2, C=bit 1 and V=bit 0. With `set_flags` low, `flags_out` equals `flags_in` for every opcode.
- R7: With `set_flags` high, N equals bit 31 of the result, and Z is 1 exactly when the result is all zeros.
- R8: With `set_flags` high, C depends on the opcode as follows:
  - For a move, C is the last bit shifted out. That bit is `op_b[32-n]` for logical left by n, `op_b[n-1]` for either right shift, and the result's bit 31 for rotate.
  - For add, C is the adder carry-out.
  - For subtract, C is 1 when no borrow occurs, which means `op_a` is at least the shifted `op_b` as unsigned values.
- R9: With `set_flags` high, V keeps `flags_in[0]` for a move. For add and subtract, V is two's-complement signed overflow of the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, fed through the shifter |
| shift_kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate |
| shift_amt | input | 5 | Shift amount 0..31 |
| alu_op | input | 2 | 00 move, 01 add, 10 subtract, 11 alternate move |
| set_flags | input | 1 | Recompute flags when high |
| flags_in | input | 4 | Incoming N,Z,C,V; bit 1 is the incoming carry |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Outgoing N,Z,C,V |

## Verification
The block has no clock, so the checker uses immediate assertions on the settled combinational outputs. Those assertions assume that every input holds a known value and that all inputs change together before the outputs are looked at. The stimulus meets that assumption by changing every input at once at a clock edge and reading the outputs a few nanoseconds later. The sweep covers every kind, every amount, every opcode, both settings of `set_flags` and both states of the incoming carry. The operand patterns drive the corner cases: carry-out, zero results, signed overflow and sign fill.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        ALU_MOV  = 2'b00,
        ALU_ADD  = 2'b01,
        ALU_SUB  = 2'b10,
        ALU_MOVX = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/shift_alu_shifter.sv
module shift_alu_shifter
    import shift_alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] amount,
    input  logic          carry_in,
    output logic [W-1:0]  shifted,
    output logic          carry_out
);

    // One stage of the logarithmic shifter: returns {carry, value}.
    function automatic logic [W:0] stage_fn(input logic [W-1:0] x,
                                            input logic [1:0]   k,
                                            input int           s);
        logic [AW-1:0] hi_idx;
        logic [AW-1:0] lo_idx;
        logic [W-1:0]  v;
        logic          c;
        hi_idx = AW'(W - s);
        lo_idx = AW'(s - 1);
        unique case (shift_kind_e'(k))
            SHK_LSL: begin
                v = x << s;
                c = x[hi_idx];
            end
            SHK_LSR: begin
                v = x >> s;
                c = x[lo_idx];
            end
            SHK_ASR: begin
                v = $signed(x) >>> s;
                c = x[lo_idx];
            end
            default: begin
                v = (x >> s) | (x << (W - s));
                c = x[lo_idx];
            end
        endcase
        return {c, v};
    endfunction

    logic [W-1:0] stage_val [0:AW];
    logic         stage_c   [0:AW];

    assign stage_val[0] = operand;
    assign stage_c[0]   = carry_in;

    for (genvar g = 0; g < AW; g++) begin : g_stage
        localparam int STEP = 1 << g;
        logic [W:0] step_res;
        assign step_res         = stage_fn(stage_val[g], kind, STEP);
        assign stage_val[g + 1] = amount[g] ? step_res[W-1:0] : stage_val[g];
        assign stage_c[g + 1]   = amount[g] ? step_res[W]     : stage_c[g];
    end

    assign shifted   = stage_val[AW];
    assign carry_out = stage_c[AW];

endmodule

// File: rtl/shift_alu_addsub.sv
module shift_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         overflow
);

    logic [W-1:0] rhs_eff;
    logic [W:0]   wide;

    assign rhs_eff   = subtract ? ~rhs : rhs;
    assign wide      = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, subtract};
    assign sum       = wide[W-1:0];
    assign carry_out = wide[W];
    assign overflow  = (lhs[W-1] == rhs_eff[W-1]) && (wide[W-1] != lhs[W-1]);

endmodule

// File: rtl/shift_alu_flags.sv
module shift_alu_flags
    import shift_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   op,
    input  logic         set_flags,
    input  logic [W-1:0] res,
    input  logic         shift_c,
    input  logic         arith_c,
    input  logic         arith_v,
    input  logic [3:0]   prev,
    output logic [3:0]   next
);

    flags_t old_f;
    flags_t new_f;

    assign old_f = flags_t'(prev);

    always_comb begin
        new_f   = old_f;
        new_f.n = res[W-1];
        new_f.z = (res == '0);
        unique case (alu_op_e'(op))
            ALU_ADD, ALU_SUB: begin
                new_f.c = arith_c;
                new_f.v = arith_v;
            end
            default: begin
                new_f.c = shift_c;
                new_f.v = old_f.v;
            end
        endcase
    end

    assign next = set_flags ? new_f : old_f;

endmodule

// File: rtl/shift_alu.sv
module shift_alu
    import shift_alu_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [1:0]    shift_kind,
    input  logic [AW-1:0] shift_amt,
    input  logic [1:0]    alu_op,
    input  logic          set_flags,
    input  logic [3:0]    flags_in,
    output logic [W-1:0]  result,
    output logic [3:0]    flags_out
);

    logic [W-1:0] b_shifted;
    logic         sh_carry;
    logic [W-1:0] arith_sum;
    logic         arith_c;
    logic         arith_v;
    logic         is_sub;
    logic         is_arith;

    assign is_sub   = (alu_op_e'(alu_op) == ALU_SUB);
    assign is_arith = (alu_op_e'(alu_op) == ALU_ADD) || is_sub;

    shift_alu_shifter #(.W(W), .AW(AW)) u_shift (
        .operand  (op_b),
        .kind     (shift_kind),
        .amount   (shift_amt),
        .carry_in (flags_in[1]),
        .shifted  (b_shifted),
        .carry_out(sh_carry)
    );

    shift_alu_addsub #(.W(W)) u_arith (
        .lhs      (op_a),
        .rhs      (b_shifted),
        .subtract (is_sub),
        .sum      (arith_sum),
        .carry_out(arith_c),
        .overflow (arith_v)
    );

    assign result = is_arith ? arith_sum : b_shifted;

    shift_alu_flags #(.W(W)) u_flags (
        .op       (alu_op),
        .set_flags(set_flags),
        .res      (result),
        .shift_c  (sh_carry),
        .arith_c  (arith_c),
        .arith_v  (arith_v),
        .prev     (flags_in),
        .next     (flags_out)
    );

endmodule

// File: rtl/shift_alu_chk.sv
module shift_alu_chk #(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input logic [W-1:0]  op_a,
    input logic [W-1:0]  op_b,
    input logic [1:0]    shift_kind,
    input logic [AW-1:0] shift_amt,
    input logic [1:0]    alu_op,
    input logic          set_flags,
    input logic [3:0]    flags_in,
    input logic [W-1:0]  result,
    input logic [3:0]    flags_out
);

    logic is_move;
    assign is_move = (alu_op == 2'b00) || (alu_op == 2'b11);

    always_comb begin
        if (!set_flags)
            AST_FLAGS_HELD: assert (flags_out == flags_in) else $error("flags changed without set_flags"); // R6
        if (set_flags)
            AST_NEG_BIT: assert (flags_out[3] == result[W-1]) else $error("N mismatch"); // R7
        if (set_flags)
            AST_ZERO_BIT: assert (flags_out[2] == (result == '0)) else $error("Z mismatch"); // R7
        if (set_flags && is_move)
            AST_MOVE_KEEPS_V: assert (flags_out[0] == flags_in[0]) else $error("V altered by move"); // R9
        if (is_move && shift_amt == '0)
            AST_ZERO_SHIFT_PASS: assert (result == op_b) else $error("zero shift altered operand"); // R2
        if (set_flags && is_move && shift_amt == '0)
            AST_ZERO_SHIFT_CARRY: assert (flags_out[1] == flags_in[1]) else $error("zero shift altered carry"); // R2
        if (set_flags && alu_op == 2'b10 && shift_amt == '0)
            AST_SUB_NO_BORROW: assert (flags_out[1] == (op_a >= op_b)) else $error("subtract carry wrong"); // R8
    end

endmodule

bind shift_alu shift_alu_chk #(.W(W)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .shift_kind(shift_kind),
    .shift_amt (shift_amt),
    .alu_op    (alu_op),
    .set_flags (set_flags),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/shift_alu_test.sv
`timescale 1ns/1ps
module shift_alu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic [1:0]  alu_op = '0;
    logic        set_flags = 1'b0;
    logic [3:0]  flags_in = '0;
    logic [31:0] result;
    logic [3:0]  flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shift_alu uut (
        .op_a      (op_a),
        .op_b      (op_b),
        .shift_kind(shift_kind),
        .shift_amt (shift_amt),
        .alu_op    (alu_op),
        .set_flags (set_flags),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out)
    );

    localparam logic [31:0] PAT_B [6] = '{32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF,
                                          32'h0000_0000, 32'h7FFF_FFFF, 32'hA5C3_0F96};
    localparam logic [31:0] PAT_A [5] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                                          32'h8000_0000, 32'hFFFF_FFFF};
    localparam logic [3:0]  PAT_F [2] = '{4'b0010, 4'b1101};

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // Reference model, from the requirements only.
    task automatic model(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] k, input logic [4:0] n,
                         input logic [1:0] op, input logic sf,
                         input logic [3:0] fin,
                         output logic [31:0] res, output logic [3:0] fout);
        logic [31:0] sh;
        logic        shc;
        logic [63:0] t;
        logic        c;
        logic        v;
        longint      sa;
        longint      sb;
        longint      sr;
        int          amt;
        amt = int'(n);
        if (amt == 0) begin
            sh  = b;
            shc = fin[1];
        end else begin
            case (k)
                2'b00: begin t = {32'h0, b} << amt; sh = t[31:0]; shc = t[32]; end
                2'b01: begin t = {b, 32'h0} >> amt; sh = t[63:32]; shc = t[31]; end
                2'b10: begin t = $signed({b, 32'h0}) >>> amt; sh = t[63:32]; shc = t[31]; end
                default: begin sh = (b >> amt) | (b << (32 - amt)); shc = sh[31]; end
            endcase
        end
        sa = longint'($signed(a));
        sb = longint'($signed(sh));
        case (op)
            2'b01: begin
                t   = {32'h0, a} + {32'h0, sh};
                res = t[31:0];
                c   = t[32];
                sr  = sa + sb;
                v   = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            2'b10: begin
                res = a - sh;
                c   = (a >= sh);
                sr  = sa - sb;
                v   = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            default: begin
                res = sh;
                c   = shc;
                v   = fin[0];
            end
        endcase
        if (sf) fout = {res[31], (res == 32'h0), c, v};
        else    fout = fin;
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] k, input logic [4:0] n,
                         input logic [1:0] op, input logic sf,
                         input logic [3:0] fin);
        logic [31:0] er;
        logic [3:0]  ef;
        string       rtag;
        @(posedge clk);
        op_a = a; op_b = b; shift_kind = k; shift_amt = n;
        alu_op = op; set_flags = sf; flags_in = fin;
        #2;
        model(a, b, k, n, op, sf, fin, er, ef);
        if (op == 2'b01)      rtag = "R4";
        else if (op == 2'b10) rtag = "R5";
        else if (n == 5'd0)   rtag = "R2";
        else if (a != 32'h0)  rtag = "R3";
        else                  rtag = "R1";
        check(rtag, "result", result, er);
        if (!sf) begin
            check("R6", "flags", {28'h0, flags_out}, {28'h0, ef});
        end else begin
            check("R7", "N", {31'h0, flags_out[3]}, {31'h0, ef[3]});
            check("R7", "Z", {31'h0, flags_out[2]}, {31'h0, ef[2]});
            check("R8", "C", {31'h0, flags_out[1]}, {31'h0, ef[1]});
            check("R9", "V", {31'h0, flags_out[0]}, {31'h0, ef[0]});
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // Idle state with all inputs low: result zero, flags pass through.
        #2;
        check("R6", "idle flags", {28'h0, flags_out}, 32'h0);
        check("R3", "idle result", result, 32'h0);

        // R1 directed: add with left shift by two.
        apply(32'h0000_0010, 32'h0000_0003, 2'b00, 5'd2, 2'b01, 1'b1, 4'b0000);
        check("R1", "add lsl2", result, 32'h0000_001C);
        // R5 directed: operand order of subtract.
        apply(32'h0000_0005, 32'h0000_0007, 2'b00, 5'd0, 2'b10, 1'b1, 4'b0000);
        check("R5", "sub order", result, 32'hFFFF_FFFE);
        check("R8", "sub borrow", {31'h0, flags_out[1]}, 32'h0);

        for (int k = 0; k < 4; k++)
            for (int n = 0; n < 32; n++)
                for (int ib = 0; ib < 6; ib++)
                    for (int op = 0; op < 4; op++)
                        for (int sf = 0; sf < 2; sf++)
                            for (int ia = 0; ia < 5; ia++)
                                for (int fi = 0; fi < 2; fi++)
                                    apply(PAT_A[ia], PAT_B[ib], 2'(k), 5'(n),
                                          2'(op), 1'(sf), PAT_F[fi]);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule